// File: doc/BRIEF.md
# Access-Per-Cycle Throughput Monitor

This block watches the memory activity of one level of a cache hierarchy and measures its throughput as accesses per cycle. It keeps two saturating counters. The first adds up the memory accesses requested at that level. The second counts the cycles in which at least one access is in flight anywhere in the level. An access is in flight when it is a new request on the processor/cache interface, when it sits in a cache pipeline stage, or when the miss-tracking table still holds it. When several accesses overlap in one cycle, that cycle counts only once, so the measured figure takes memory concurrency into account instead of adding up latencies.

A second mode gives the main-memory figure. In that mode the first counter counts DRAM accesses, and the second counts the cycles in which the last-level cache's miss-tracking table is not empty. Both counters advance only while counting is enabled, and a clear pulse zeroes them. A ratio request takes a snapshot of both counters and runs a restoring divider, one quotient bit per cycle. The divider returns the quotient as unsigned 16.16 fixed point and raises a one-cycle done pulse.

Top module: `apc_monitor`

## Requirements
- R1: In level mode (`mode_main`=0) with counting enabled, `access_count` grows each cycle by the number of asserted bits of `req_strobe`, from 0 to NUM_PORTS.
- R2: In level mode with counting enabled, `active_count` grows by exactly one in every cycle in which any bit of `req_strobe` or of `pipe_valid` is set or `mshr_busy` is high. In any other cycle it keeps its value, and it never grows by more than one in a cycle.
- R3: In main-memory mode (`mode_main`=1), `access_count` grows by one per cycle with `dram_access` high, and `active_count` grows by one per cycle with `llc_mshr_busy` high. `req_strobe`, `pipe_valid` and `mshr_busy` have no effect in this mode.
- R4: While `cnt_enable` is low, both counters keep their values whatever the activity inputs do.
- R5: A `cnt_clear` pulse zeroes both counters and `overflow` at the next clock edge. It wins over an increment requested in the same cycle.
- R6: The counters saturate at all-ones instead of wrapping. `overflow` is set when an increment would carry either counter past all-ones, and it stays set until a clear.
- R7: A ratio request latches both counter values at the start edge. `ratio_q` then reads floor(access*65536/active) as 16.16 fixed point, limited to all-ones. Counter changes during the division do not alter the result.
- R8: For a non-zero divisor, `ratio_done` pulses high for one cycle exactly CNT_W+16 clock edges after the start edge. `ratio_busy` is high in between, and `ratio_start` is ignored while busy.
- R9: If the latched active count is zero, `ratio_done` is high right after the start edge, with `ratio_q`=0 and `div_by_zero`=1. The next ratio request with a non-zero divisor clears `div_by_zero`.
- R10: After reset, both counters, `overflow`, `ratio_q`, `ratio_busy`, `ratio_done` and `div_by_zero` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_main | input | 1 | 0: level figure, 1: main-memory figure |
| cnt_enable | input | 1 | Counters advance while high |
| cnt_clear | input | 1 | Zeroes counters and overflow |
| req_strobe | input | NUM_PORTS | New access requests this cycle, one per port |
| pipe_valid | input | PIPE_STAGES | Valid bit of each cache pipeline stage |
| mshr_busy | input | 1 | Miss-tracking table of this level not empty |
| dram_access | input | 1 | A DRAM access issued this cycle |
| llc_mshr_busy | input | 1 | Last-level miss-tracking table not empty |
| ratio_start | input | 1 | Request a ratio computation |
| access_count | output | CNT_W | Access counter |
| active_count | output | CNT_W | Active-cycle counter |
| overflow | output | 1 | Sticky saturation flag |
| ratio_busy | output | 1 | Divider running |
| ratio_done | output | 1 | One-cycle result pulse |
| ratio_q | output | 32 | Quotient, unsigned 16.16 |
| div_by_zero | output | 1 | Last ratio had a zero divisor |

## Verification
The assertions assume that reset is applied before any activity and that the mode input is held steady while the counters run. The stimulus only changes `mode_main` together with a clear. The assertions also assume that `ratio_start` may come at any time, including while the divider is busy. The bench issues starts mid-division on purpose and checks that the earlier snapshot wins. The activity inputs are driven through every combination of the small configuration, one step after the clock edge, so each sample sees settled values.

// File: rtl/apc_pkg.sv
package apc_pkg;
  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_MAIN  = 1'b1
  } apc_mode_e;

  localparam int FRAC_W  = 16;
  localparam int RATIO_W = 32;
endpackage

// File: rtl/apc_activity.sv
module apc_activity
  import apc_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int PIPE_STAGES = 3,
  parameter int INC_W       = $clog2(NUM_PORTS + 1)
) (
  input  logic                   mode_main,
  input  logic [NUM_PORTS-1:0]   req_strobe,
  input  logic [PIPE_STAGES-1:0] pipe_valid,
  input  logic                   mshr_busy,
  input  logic                   dram_access,
  input  logic                   llc_mshr_busy,
  output logic [INC_W-1:0]       access_inc,
  output logic                   cycle_active
);
  function automatic logic [INC_W-1:0] count_ones(input logic [NUM_PORTS-1:0] v);
    logic [INC_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_PORTS; i++) n = n + INC_W'(v[i]);
    return n;
  endfunction

  logic level_active;
  logic [INC_W-1:0] level_inc;

  assign level_inc    = count_ones(req_strobe);
  assign level_active = (|req_strobe) | (|pipe_valid) | mshr_busy;

  always_comb begin
    if (apc_mode_e'(mode_main) == MODE_MAIN) begin
      access_inc   = INC_W'(dram_access);
      cycle_active = llc_mshr_busy;
    end else begin
      access_inc   = level_inc;
      cycle_active = level_active;
    end
  end
endmodule

// File: rtl/apc_sat_counter.sv
module apc_sat_counter #(
  parameter int W     = 48,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt,
  output logic             sat_evt
);
  function automatic logic [W:0] sat_add(input logic [W-1:0] a, input logic [INC_W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + (W+1)'(b);
    if (s[W]) return {1'b1, {W{1'b1}}};
    return s;
  endfunction

  logic [W:0] next_sum;
  assign next_sum = sat_add(cnt, inc);
  assign sat_evt  = en & ~clr & next_sum[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= next_sum[W-1:0];
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R5
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (cnt >= $past(cnt))); // R6
endmodule

// File: rtl/apc_ratio_div.sv
module apc_ratio_div #(
  parameter int CNT_W   = 48,
  parameter int FRAC_W  = 16,
  parameter int RATIO_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   num,
  input  logic [CNT_W-1:0]   den,
  output logic               busy,
  output logic               done,
  output logic [RATIO_W-1:0] quotient,
  output logic               dbz
);
  localparam int QW     = CNT_W + FRAC_W;
  localparam int STEP_W = $clog2(QW + 1);

  logic [CNT_W:0]   rem;
  logic [QW-1:0]    dvd;
  logic [QW-1:0]    q;
  logic [CNT_W-1:0] den_r;
  logic [STEP_W-1:0] step;

  logic [CNT_W:0] trial;
  logic           q_bit;
  logic [CNT_W:0] rem_next;
  logic [QW-1:0]  q_next;
  logic           last_step;

  function automatic logic [RATIO_W-1:0] clamp(input logic [QW-1:0] v);
    logic [QW+RATIO_W-1:0] wide;
    wide = {{RATIO_W{1'b0}}, v};
    if (wide[QW+RATIO_W-1:RATIO_W] != '0) return '1;
    return wide[RATIO_W-1:0];
  endfunction

  assign trial     = {rem[CNT_W-1:0], dvd[QW-1]};
  assign q_bit     = (trial >= {1'b0, den_r});
  assign rem_next  = q_bit ? (trial - {1'b0, den_r}) : trial;
  assign q_next    = {q[QW-2:0], q_bit};
  assign last_step = (step == STEP_W'(QW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; dvd <= '0; q <= '0; den_r <= '0; step <= '0;
      busy <= 1'b0; done <= 1'b0; quotient <= '0; dbz <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        rem  <= rem_next;
        dvd  <= {dvd[QW-2:0], 1'b0};
        q    <= q_next;
        step <= step + 1'b1;
        if (last_step) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          quotient <= clamp(q_next);
        end
      end else if (start) begin
        if (den == '0) begin
          done     <= 1'b1;
          quotient <= '0;
          dbz      <= 1'b1;
        end else begin
          rem   <= '0;
          dvd   <= {num, {FRAC_W{1'b0}}};
          q     <= '0;
          den_r <= den;
          step  <= '0;
          busy  <= 1'b1;
          dbz   <= 1'b0;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R8
  AST_DBZ_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dbz) |-> (quotient == '0)); // R9
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem < {1'b0, den_r})); // R7
endmodule

// File: rtl/apc_monitor.sv
module apc_monitor
  import apc_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int PIPE_STAGES = 3,
  parameter int CNT_W       = 48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_main,
  input  logic                   cnt_enable,
  input  logic                   cnt_clear,
  input  logic [NUM_PORTS-1:0]   req_strobe,
  input  logic [PIPE_STAGES-1:0] pipe_valid,
  input  logic                   mshr_busy,
  input  logic                   dram_access,
  input  logic                   llc_mshr_busy,
  input  logic                   ratio_start,
  output logic [CNT_W-1:0]       access_count,
  output logic [CNT_W-1:0]       active_count,
  output logic                   overflow,
  output logic                   ratio_busy,
  output logic                   ratio_done,
  output logic [RATIO_W-1:0]     ratio_q,
  output logic                   div_by_zero
);
  localparam int INC_W = $clog2(NUM_PORTS + 1);

  logic [INC_W-1:0] access_inc;
  logic             cycle_active;
  logic             acc_sat_evt;
  logic             act_sat_evt;

  apc_activity #(.NUM_PORTS(NUM_PORTS), .PIPE_STAGES(PIPE_STAGES), .INC_W(INC_W)) u_activity (
    .mode_main(mode_main), .req_strobe(req_strobe), .pipe_valid(pipe_valid),
    .mshr_busy(mshr_busy), .dram_access(dram_access), .llc_mshr_busy(llc_mshr_busy),
    .access_inc(access_inc), .cycle_active(cycle_active)
  );

  apc_sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_acc_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_enable), .clr(cnt_clear),
    .inc(access_inc), .cnt(access_count), .sat_evt(acc_sat_evt)
  );

  apc_sat_counter #(.W(CNT_W), .INC_W(1)) u_act_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_enable), .clr(cnt_clear),
    .inc(cycle_active), .cnt(active_count), .sat_evt(act_sat_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         overflow <= 1'b0;
    else if (cnt_clear)                 overflow <= 1'b0;
    else if (acc_sat_evt | act_sat_evt) overflow <= 1'b1;
  end

  apc_ratio_div #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .RATIO_W(RATIO_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(ratio_start),
    .num(access_count), .den(active_count),
    .busy(ratio_busy), .done(ratio_done), .quotient(ratio_q), .dbz(div_by_zero)
  );

  AST_ACTIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> ((active_count - $past(active_count)) <= CNT_W'(1))); // R2
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clear && !cycle_active) |=> $stable(active_count)); // R2
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !cnt_clear) |=> overflow); // R6
  AST_CLEAR_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> !overflow); // R5
endmodule

// File: tb/apc_monitor_tb.sv
module apc_monitor_tb;
  localparam int NP  = 3;
  localparam int PS  = 2;
  localparam int CW  = 10;
  localparam int QW  = CW + 16;
  localparam longint MAXC = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_main = 1'b0, cnt_enable = 1'b0, cnt_clear = 1'b0;
  logic [NP-1:0] req_strobe = '0;
  logic [PS-1:0] pipe_valid = '0;
  logic mshr_busy = 1'b0, dram_access = 1'b0, llc_mshr_busy = 1'b0, ratio_start = 1'b0;
  logic [CW-1:0] access_count, active_count;
  logic overflow, ratio_busy, ratio_done, div_by_zero;
  logic [31:0] ratio_q;

  int checks = 0;
  int failures = 0;
  longint m_acc = 0, m_act = 0;
  logic m_ov = 1'b0;

  always #4 clk = ~clk;

  apc_monitor #(.NUM_PORTS(NP), .PIPE_STAGES(PS), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_main(mode_main), .cnt_enable(cnt_enable),
    .cnt_clear(cnt_clear), .req_strobe(req_strobe), .pipe_valid(pipe_valid),
    .mshr_busy(mshr_busy), .dram_access(dram_access), .llc_mshr_busy(llc_mshr_busy),
    .ratio_start(ratio_start), .access_count(access_count), .active_count(active_count),
    .overflow(overflow), .ratio_busy(ratio_busy), .ratio_done(ratio_done),
    .ratio_q(ratio_q), .div_by_zero(div_by_zero)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    longint inc, sum;
    logic   actv;
    @(posedge clk);
    if (cnt_clear) begin
      m_acc = 0; m_act = 0; m_ov = 1'b0;
    end else if (cnt_enable) begin
      if (mode_main) begin
        inc  = dram_access;
        actv = llc_mshr_busy;
      end else begin
        inc  = $countones(req_strobe);
        actv = (req_strobe != 0) || (pipe_valid != 0) || mshr_busy;
      end
      sum = m_acc + inc;
      if (sum > MAXC) begin m_ov = 1'b1; sum = MAXC; end
      m_acc = sum;
      sum = m_act + (actv ? 1 : 0);
      if (sum > MAXC) begin m_ov = 1'b1; sum = MAXC; end
      m_act = sum;
    end
    #1;
  endtask

  task automatic check_counts(input string tag);
    check({tag, " access"}, access_count, m_acc);
    check({tag, " active"}, active_count, m_act);
    check({tag, " overflow"}, overflow, m_ov);
  endtask

  task automatic run_ratio(input string tag);
    longint sa, sc, exp;
    int lat;
    sa = m_acc; sc = m_act;
    ratio_start = 1'b1;
    tick();
    ratio_start = 1'b0;
    lat = 0;
    while (!ratio_done && lat < 200) begin
      if (lat == 5) ratio_start = 1'b1;
      tick();
      ratio_start = 1'b0;
      lat++;
    end
    if (sc == 0) begin
      check({tag, " R9 latency"}, lat, 0);
      check({tag, " R9 quotient"}, ratio_q, 0);
      check({tag, " R9 dbz"}, div_by_zero, 1);
    end else begin
      exp = (sa << 16) / sc;
      if (exp > 64'hFFFF_FFFF) exp = 64'hFFFF_FFFF;
      check({tag, " R8 latency"}, lat, QW);
      check({tag, " R7 quotient"}, ratio_q, exp);
      check({tag, " R9 dbz clear"}, div_by_zero, 0);
    end
    tick();
    check({tag, " R8 done pulse"}, ratio_done, 0);
  endtask

  initial begin
    #(8 * 190000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10 access", access_count, 0);
    check("R10 active", active_count, 0);
    check("R10 overflow", overflow, 0);
    check("R10 quotient", ratio_q, 0);
    check("R10 busy", ratio_busy, 0);
    check("R10 done", ratio_done, 0);
    check("R10 dbz", div_by_zero, 0);

    // R9: zero divisor right after reset
    run_ratio("zero-div");

    // R1 R2: exhaustive sweep of level-mode sources
    cnt_enable = 1'b1;
    for (int i = 0; i < 64; i++) begin
      req_strobe = i[2:0]; pipe_valid = i[4:3]; mshr_busy = i[5];
      tick();
      check_counts("R1 R2 sweep");
    end
    for (int i = 0; i < 8; i++) begin
      req_strobe = '0; pipe_valid = '0; mshr_busy = 1'b0;
      tick();
      check_counts("R2 idle");
    end
    req_strobe = 3'b101; pipe_valid = 2'b01;
    // R7 R8: ratio with counters moving during division
    run_ratio("level ratio");

    // R4: enable low
    cnt_enable = 1'b0;
    for (int i = 0; i < 16; i++) begin
      req_strobe = i[2:0]; mshr_busy = i[3]; pipe_valid = '1;
      tick();
      check_counts("R4 disabled");
    end

    // R5: clear beats increment
    cnt_enable = 1'b1; cnt_clear = 1'b1; req_strobe = '1;
    tick();
    cnt_clear = 1'b0;
    check("R5 clear access", access_count, 0);
    check("R5 clear active", active_count, 0);

    // R3: main-memory mode, level inputs as noise
    req_strobe = '0; cnt_enable = 1'b0; cnt_clear = 1'b1; mode_main = 1'b1;
    tick();
    cnt_clear = 1'b0; cnt_enable = 1'b1;
    for (int i = 0; i < 32; i++) begin
      dram_access = i[0]; llc_mshr_busy = i[1] | i[2];
      req_strobe = i[4:2]; pipe_valid = i[3:2]; mshr_busy = i[4];
      tick();
      check_counts("R3 main");
    end
    dram_access = 1'b1; llc_mshr_busy = 1'b0;
    run_ratio("main ratio");

    // R9 then clear of dbz
    dram_access = 1'b0; cnt_clear = 1'b1;
    tick();
    cnt_clear = 1'b0;
    run_ratio("zero-div again");
    llc_mshr_busy = 1'b1; dram_access = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    run_ratio("after zero");

    // R6: saturation and sticky overflow
    cnt_clear = 1'b1; mode_main = 1'b0;
    tick();
    cnt_clear = 1'b0; dram_access = 1'b0; llc_mshr_busy = 1'b0;
    req_strobe = '1; pipe_valid = '0; mshr_busy = 1'b0;
    for (int i = 0; i < 1100; i++) tick();
    check_counts("R6 saturated");
    check("R6 access max", access_count, MAXC);
    check("R6 overflow", overflow, 1);
    req_strobe = '0;
    for (int i = 0; i < 4; i++) tick();
    check("R6 overflow sticky", overflow, 1);
    run_ratio("saturated ratio");
    cnt_clear = 1'b1;
    tick();
    cnt_clear = 1'b0;
    check("R5 overflow cleared", overflow, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule